// File: doc/BRIEF.md
# SIMD Dot-Product Filter Datapath

This block is the filtering slice of a small processing element's execution unit. It holds a pixel window register and twelve coefficient words. Each coefficient word packs four unsigned 8-bit filter taps. A dot operation multiplies the four pixel bytes by the four taps of one chosen coefficient word, lane by lane. It sums the four products and adds that sum to a 24-bit accumulator, all in one clock cycle. Each dot operation therefore counts as four multiplies and four adds.

A window-shift operation moves the pixel register up by one byte and puts a freshly loaded byte into the lowest lane. A run of shift operations, each followed by dot operations against a fixed set of coefficient words, slides a filter mask along a pixel row one pixel at a time. A clear operation empties the accumulator between output pixels. Coefficients are loaded through their own write port, which works independently of the operation stream.

Top module: `pix_mac_slice`

## Requirements
- R1: While `rst` is high at a clock edge, `acc_o` and `pix_o` are zero after that edge.
- R2: When `op_valid_i` is 1 and `op_code_i` is 2'b01 (dot), `acc_o` after the edge equals its old value plus the sum over lanes k=0..3 of `pix_o[8k+7:8k]` times byte k of coefficient word `coef_sel_i`. All values are unsigned. `pix_o` is left unchanged.
- R3: The accumulator wraps modulo 2^24 when a dot sum carries past bit 23.
- R4: When `op_valid_i` is 1 and `op_code_i` is 2'b10 (shift), `pix_o` becomes {old `pix_o[23:0]`, `load_byte_i`}. The oldest byte is dropped and `acc_o` is left unchanged.
- R5: When `op_valid_i` is 1 and `op_code_i` is 2'b11 (clear), `acc_o` becomes zero and `pix_o` is left unchanged.
- R6: When `cw_en_i` is 1 and `cw_idx_i` is 0..11, coefficient word `cw_idx_i` takes `cw_data_i` at the edge. A dot in that same cycle uses the old word. Dots from the next cycle on use the new word.
- R7: A coefficient write with `cw_idx_i` of 12..15 changes no coefficient word.
- R8: A dot with `coef_sel_i` of 12..15 reads an all-zero word, so `acc_o` is unchanged.
- R9: When `op_valid_i` is 0, or `op_code_i` is 2'b00, `acc_o` and `pix_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid_i | input | 1 | Operation valid |
| op_code_i | input | 2 | 00 idle, 01 dot, 10 shift, 11 clear |
| coef_sel_i | input | 4 | Coefficient word used by a dot |
| load_byte_i | input | 8 | Byte inserted by a shift |
| cw_en_i | input | 1 | Coefficient write enable |
| cw_idx_i | input | 4 | Coefficient word written |
| cw_data_i | input | 32 | Coefficient word data, byte k is lane k |
| acc_o | output | 24 | Accumulator |
| pix_o | output | 32 | Pixel window register |

## Verification
The bench aims at four corner cases.

- Lane alignment: it drives byte patterns that differ in every lane. A design that pairs pixel and tap lanes wrongly, or shifts toward the wrong end, then gives a different `acc_o` or `pix_o`.
- Accumulator wrap: it repeats all-ones dot products until the 24-bit accumulator wraps. A design that saturates or truncates the sum too early shows a wrong value there.
- Same-cycle write and dot: it writes a coefficient word while a dot reads that same word, to expose a design that forwards the new data.
- Out-of-range indices: it uses indices 12 to 15 for both writes and dot selection. A design that aliases them onto words 0 to 3 corrupts later dot results or adds non-zero sums.

// File: rtl/pix_mac_pkg.sv
package pix_mac_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'b00,
    OP_DOT   = 2'b01,
    OP_SHIFT = 2'b10,
    OP_CLR   = 2'b11
  } pix_op_e;
endpackage

// File: rtl/pix_coef_bank.sv
// Coefficient word store: synchronous write, asynchronous read, so it maps to distributed RAM.
module pix_coef_bank #(
  parameter int NCOEF  = 12,
  parameter int IDX_W  = 4,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NCOEF);

  logic [WORD_W-1:0] mem [NCOEF];

  always_ff @(posedge clk) begin
    if (wr_en && (wr_idx < LIMIT)) mem[wr_idx] <= wr_data;
  end

  always_comb begin
    if (rd_idx < LIMIT) rd_data = mem[rd_idx];
    else                rd_data = '0;
  end
endmodule

// File: rtl/pix_dot4.sv
// Lane-wise unsigned multiply followed by a reduction sum.
module pix_dot4 #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  localparam int WORD_W = LANES * PIX_W,
  localparam int PROD_W = 2 * PIX_W,
  localparam int SUM_W  = PROD_W + $clog2(LANES)
) (
  input  logic [WORD_W-1:0] pix,
  input  logic [WORD_W-1:0] coef,
  output logic [SUM_W-1:0]  sum
);
  logic [PROD_W-1:0] prod [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign prod[k] = pix[k*PIX_W +: PIX_W] * coef[k*PIX_W +: PIX_W];
  end

  always_comb begin
    sum = '0;
    for (int k = 0; k < LANES; k++) sum = sum + SUM_W'(prod[k]);
  end
endmodule

// File: rtl/pix_win_shift.sv
// Pixel window: shifts up one lane and takes a new byte into lane 0.
module pix_win_shift #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  localparam int WORD_W = LANES * PIX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic [PIX_W-1:0]  byte_in,
  output logic [WORD_W-1:0] window
);
  always_ff @(posedge clk) begin
    if (rst)           window <= '0;
    else if (shift_en) window <= {window[WORD_W-PIX_W-1:0], byte_in};
  end
endmodule

// File: rtl/pix_mac_slice.sv
module pix_mac_slice
  import pix_mac_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  parameter int NCOEF = 12,
  parameter int IDX_W = 4,
  localparam int WORD_W = LANES * PIX_W,
  localparam int SUM_W  = 2 * PIX_W + $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid_i,
  input  logic [1:0]        op_code_i,
  input  logic [IDX_W-1:0]  coef_sel_i,
  input  logic [PIX_W-1:0]  load_byte_i,
  input  logic              cw_en_i,
  input  logic [IDX_W-1:0]  cw_idx_i,
  input  logic [WORD_W-1:0] cw_data_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic [WORD_W-1:0] pix_o
);
  pix_op_e           op;
  logic [WORD_W-1:0] coef_word;
  logic [SUM_W-1:0]  dot_sum;
  logic [ACC_W-1:0]  acc_q;
  logic [WORD_W-1:0] window;

  assign op = pix_op_e'(op_code_i);

  pix_coef_bank #(.NCOEF(NCOEF), .IDX_W(IDX_W), .WORD_W(WORD_W)) u_bank (
    .clk     (clk),
    .wr_en   (cw_en_i),
    .wr_idx  (cw_idx_i),
    .wr_data (cw_data_i),
    .rd_idx  (coef_sel_i),
    .rd_data (coef_word)
  );

  pix_dot4 #(.LANES(LANES), .PIX_W(PIX_W)) u_dot (
    .pix  (window),
    .coef (coef_word),
    .sum  (dot_sum)
  );

  pix_win_shift #(.LANES(LANES), .PIX_W(PIX_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .shift_en (op_valid_i && (op == OP_SHIFT)),
    .byte_in  (load_byte_i),
    .window   (window)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (op_valid_i) begin
      case (op)
        OP_DOT:  acc_q <= acc_q + ACC_W'(dot_sum);
        OP_CLR:  acc_q <= '0;
        default: acc_q <= acc_q;
      endcase
    end
  end

  assign acc_o = acc_q;
  assign pix_o = window;
endmodule

// File: rtl/pix_mac_chk.sv
module pix_mac_chk #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int ACC_W = 24,
  localparam int WORD_W = LANES * PIX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              op_valid_i,
  input logic [1:0]        op_code_i,
  input logic [PIX_W-1:0]  load_byte_i,
  input logic [ACC_W-1:0]  acc_o,
  input logic [WORD_W-1:0] pix_o
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (acc_o == '0 && pix_o == '0));

  // R4
  shift_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'b10) |=>
      (pix_o[WORD_W-1:PIX_W] == $past(pix_o[WORD_W-PIX_W-1:0]) &&
       pix_o[PIX_W-1:0] == $past(load_byte_i) && $stable(acc_o)));

  // R5
  clear_acc_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'b11) |=> (acc_o == '0 && $stable(pix_o)));

  // R2
  dot_keeps_pix_chk: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && op_code_i == 2'b01) |=> $stable(pix_o));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!op_valid_i || op_code_i == 2'b00) |=> ($stable(acc_o) && $stable(pix_o)));
endmodule

bind pix_mac_slice pix_mac_chk #(.LANES(LANES), .PIX_W(PIX_W), .ACC_W(ACC_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid_i  (op_valid_i),
  .op_code_i   (op_code_i),
  .load_byte_i (load_byte_i),
  .acc_o       (acc_o),
  .pix_o       (pix_o)
);

// File: tb/pix_mac_slice_bench.sv
module pix_mac_slice_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid_i;
  logic [1:0]  op_code_i;
  logic [3:0]  coef_sel_i;
  logic [7:0]  load_byte_i;
  logic        cw_en_i;
  logic [3:0]  cw_idx_i;
  logic [31:0] cw_data_i;
  logic [23:0] acc_o;
  logic [31:0] pix_o;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] coef_m [12];
  logic [23:0] acc_m;
  logic [31:0] pix_m;

  always #10 clk = ~clk;

  pix_mac_slice u_pix_mac_slice (
    .clk(clk), .rst(rst), .op_valid_i(op_valid_i), .op_code_i(op_code_i),
    .coef_sel_i(coef_sel_i), .load_byte_i(load_byte_i), .cw_en_i(cw_en_i),
    .cw_idx_i(cw_idx_i), .cw_data_i(cw_data_i), .acc_o(acc_o), .pix_o(pix_o)
  );

  function automatic logic [23:0] dot_ref(logic [31:0] p, logic [31:0] c);
    logic [23:0] s = '0;
    for (int k = 0; k < 4; k++) s = s + 24'(p[8*k +: 8]) * 24'(c[8*k +: 8]);
    return s;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge.
  task automatic step(string tag, bit v, logic [1:0] op, logic [3:0] sel,
                      logic [7:0] b, bit we, logic [3:0] wi, logic [31:0] wd);
    logic [31:0] c;
    op_valid_i = v; op_code_i = op; coef_sel_i = sel; load_byte_i = b;
    cw_en_i = we; cw_idx_i = wi; cw_data_i = wd;
    @(posedge clk);
    c = (sel < 12) ? coef_m[sel] : 32'h0;
    if (v) begin
      case (op)
        2'b01: acc_m = acc_m + dot_ref(pix_m, c);
        2'b10: pix_m = {pix_m[23:0], b};
        2'b11: acc_m = '0;
        default: ;
      endcase
    end
    if (we && wi < 12) coef_m[wi] = wd;
    @(negedge clk);
    check({tag, " acc"}, 32'(acc_o), 32'(acc_m));
    check({tag, " pix"}, pix_o, pix_m);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    r = $urandom(32'h00c0ffee);
    rst = 1; op_valid_i = 0; op_code_i = 0; coef_sel_i = 0; load_byte_i = 0;
    cw_en_i = 0; cw_idx_i = 0; cw_data_i = 0;
    acc_m = '0; pix_m = '0;
    for (int i = 0; i < 12; i++) coef_m[i] = '0;
    repeat (3) @(negedge clk);
    check("R1 acc", 32'(acc_o), 0);
    check("R1 pix", pix_o, 0);
    rst = 0;

    // R6: load every coefficient word
    for (int i = 0; i < 12; i++)
      step("R6 load", 0, 2'b00, 0, 0, 1, 4'(i), 32'h01020304 * (i + 1));

    // R4: four shifts, distinct bytes per lane
    step("R4", 1, 2'b10, 0, 8'h11, 0, 0, 0);
    step("R4", 1, 2'b10, 0, 8'h22, 0, 0, 0);
    step("R4", 1, 2'b10, 0, 8'h33, 0, 0, 0);
    step("R4", 1, 2'b10, 0, 8'h44, 0, 0, 0);
    step("R4 drop", 1, 2'b10, 0, 8'h55, 0, 0, 0);

    // R2: dots with several words
    step("R2", 1, 2'b01, 4'd0, 0, 0, 0, 0);
    step("R2", 1, 2'b01, 4'd11, 0, 0, 0, 0);
    step("R2", 1, 2'b01, 4'd5, 0, 0, 0, 0);

    // R8: out-of-range selection adds nothing
    step("R8", 1, 2'b01, 4'd12, 0, 0, 0, 0);
    step("R8", 1, 2'b01, 4'd15, 0, 0, 0, 0);

    // R9: idle and invalid cycles hold
    step("R9", 0, 2'b01, 4'd1, 8'h99, 0, 0, 0);
    step("R9", 0, 2'b10, 4'd1, 8'h99, 0, 0, 0);
    step("R9", 1, 2'b00, 4'd1, 8'h99, 0, 0, 0);

    // R5: clear
    step("R5", 1, 2'b11, 0, 8'h77, 0, 0, 0);

    // R6: write and dot on the same word in one cycle uses old data
    step("R6 same", 1, 2'b01, 4'd3, 0, 1, 4'd3, 32'hffffffff);
    step("R6 next", 1, 2'b01, 4'd3, 0, 0, 0, 0);

    // R7: writes to 12..15 disturb nothing
    for (int i = 12; i < 16; i++)
      step("R7 write", 0, 2'b00, 0, 0, 1, 4'(i), 32'hdeadbeef);
    step("R7 clr", 1, 2'b11, 0, 0, 0, 0, 0);
    for (int i = 0; i < 12; i++) step("R7 dot", 1, 2'b01, 4'(i), 0, 0, 0, 0);

    // R3: accumulate all-ones products until wrap past 2^24
    step("R3 coef", 1, 2'b11, 0, 0, 1, 4'd7, 32'hffffffff);
    for (int i = 0; i < 4; i++) step("R3 pix", 1, 2'b10, 0, 8'hff, 0, 0, 0);
    for (int i = 0; i < 70; i++) step("R3", 1, 2'b01, 4'd7, 0, 0, 0, 0);

    // R2 R4 R6: random mix of operations and writes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] a;
      a = $urandom;
      step("R2 rand", a[0] | a[1], a[3:2], a[7:4], a[15:8], a[16] & a[17],
           a[21:18], $urandom);
    end

    finish_run();
  end
endmodule